// File: doc/BRIEF.md
# Hybrid Fixed/Round-Robin Request Arbiter

This block picks one winner among several requesters that compete for a single downstream address channel. Every requester is assigned at build time to one of two classes by a parameter bit. Members of the fixed class are served strictly by index, with the lowest index first. Members of the rotating class share the channel fairly through a round-robin pointer.

Any pending request from the fixed class outranks every request from the rotating class. The grant is one-hot and is formed in the same cycle from the current request vector and the registered state. A grant that has been given stays with its owner until that owner drops its request or the completion strobe marks the handshake as finished.

The rotating pointer moves only when a completed grant belonged to the rotating class. A system that has separate read and write address channels uses one instance for each, and each instance has its own class mask.

Top module: `hybrid_req_arbiter`

## Requirements
- R1: After reset, no grant is driven and the rotating pointer starts at index 0, so the first rotating grant goes to the lowest-indexed rotating requester.
- R2: While no request is asserted, the grant vector is all zeros.
- R3: The grant has at most one bit set, and that bit is always one of the currently asserted requests.
- R4: When a fixed-class master (its bit in FIXED_MASK is 1) requests, a fixed-class master wins over every rotating-class requester.
- R5: Among requesting fixed-class masters, the one with the lowest index wins.
- R6: When a rotating-class grant to index k completes (done_i high with that grant), the next rotating choice is the first rotating requester above k, wrapping to the lowest index after the top.
- R7: The rotating pointer does not move on cycles without completion or when the completed grant went to a fixed-class master.
- R8: While the granted request stays asserted and done_i is low, the same grant is held on following cycles even if a higher-ranked request arrives.
- R9: When the held master drops its request, a fresh arbitration result appears in that same cycle.
- R10: A done_i pulse while the grant is all zeros has no effect on the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | N_REQ | Request vector, one bit per master |
| done_i | input | 1 | Handshake completion for the current grant |
| grant_o | output | N_REQ | One-hot grant (all zeros when idle) |

## Verification
Two functions can fall in the same cycle: the release of a held grant and the next arbitration decision. The first case is a completion strobe that ends a hold while a higher-ranked request is also pending. The second case is a held requester that drops its request in the very cycle a completion arrives. The bench builds both cases on purpose. It judges them by checking that the grant in the release cycle still belongs to the held owner, or else to the fresh winner when the owner has dropped its request. It also checks that the next rotating choice shows whether the pointer moved.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned MAX_REQ = 32;

  // Index of the single set bit of a one-hot vector (0 when empty).
  function automatic int unsigned oh_to_idx(input logic [MAX_REQ-1:0] vec);
    int unsigned idx;
    idx = 0;
    for (int unsigned i = 0; i < MAX_REQ; i++) begin
      if (vec[i]) idx = i;
    end
    return idx;
  endfunction
endpackage

// File: rtl/arb_lsb_pick.sv
module arb_lsb_pick #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] vec_i,
  output logic [W-1:0] pick_o
);
  // Isolate the lowest set bit.
  always_comb begin
    pick_o = vec_i & (~vec_i + W'(1));
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int unsigned W  = 4,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  rr_req_i,
  input  logic [IW-1:0] ptr_i,
  output logic [W-1:0]  pick_o
);
  logic [W-1:0] above_mask;
  logic [W-1:0] masked_req;
  logic [W-1:0] masked_pick;
  logic [W-1:0] wrap_pick;

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign above_mask[g] = (IW'(g) >= ptr_i);
  end

  always_comb begin
    masked_req = rr_req_i & above_mask;
  end

  arb_lsb_pick #(.W(W)) u_above (.vec_i(masked_req), .pick_o(masked_pick));
  arb_lsb_pick #(.W(W)) u_wrap  (.vec_i(rr_req_i),   .pick_o(wrap_pick));

  always_comb begin
    pick_o = (|masked_req) ? masked_pick : wrap_pick;
  end
endmodule

// File: rtl/arb_hold_ctl.sv
module arb_hold_ctl
  import arb_pkg::*;
#(
  parameter int unsigned     W          = 4,
  parameter logic [W-1:0]    FIXED_MASK = '0,
  localparam int unsigned    IW         = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  grant_i,
  input  logic          done_i,
  output logic          lock_o,
  output logic [W-1:0]  hold_o,
  output logic [IW-1:0] ptr_o
);
  logic          lock_q, lock_d;
  logic [W-1:0]  hold_q, hold_d;
  logic [IW-1:0] ptr_q,  ptr_d;
  logic          ptr_en;
  logic [IW-1:0] grant_idx;

  always_comb begin
    grant_idx = IW'(oh_to_idx(MAX_REQ'(grant_i)));
    ptr_en    = done_i && (|(grant_i & ~FIXED_MASK));
    ptr_d     = (grant_idx == IW'(W-1)) ? '0 : grant_idx + IW'(1);
    lock_d    = (|grant_i) && !done_i;
    hold_d    = grant_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      hold_q <= '0;
      ptr_q  <= '0;
    end else begin
      lock_q <= lock_d;
      hold_q <= hold_d;
      if (ptr_en) ptr_q <= ptr_d;
    end
  end

  assign lock_o = lock_q;
  assign hold_o = hold_q;
  assign ptr_o  = ptr_q;

  // R7 / R10: pointer only moves on a completed rotating grant
  a_r7_ptr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_i && (|(grant_i & ~FIXED_MASK))) |=> $stable(ptr_q));
endmodule

// File: rtl/hybrid_req_arbiter.sv
module hybrid_req_arbiter #(
  parameter int unsigned        N_REQ      = 5,
  parameter logic [N_REQ-1:0]   FIXED_MASK = 5'b00011,
  localparam int unsigned       IW         = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req_i,
  input  logic             done_i,
  output logic [N_REQ-1:0] grant_o
);
  logic [N_REQ-1:0] fix_req, rr_req;
  logic [N_REQ-1:0] fix_pick, rr_pick, fresh;
  logic [N_REQ-1:0] hold;
  logic [IW-1:0]    ptr;
  logic             lock;
  logic             hold_live;

  always_comb begin
    fix_req = req_i & FIXED_MASK;
    rr_req  = req_i & ~FIXED_MASK;
  end

  arb_lsb_pick #(.W(N_REQ)) u_fix (.vec_i(fix_req), .pick_o(fix_pick));

  arb_rr_pick #(.W(N_REQ)) u_rr (
    .rr_req_i(rr_req),
    .ptr_i   (ptr),
    .pick_o  (rr_pick)
  );

  arb_hold_ctl #(.W(N_REQ), .FIXED_MASK(FIXED_MASK)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .grant_i(grant_o),
    .done_i (done_i),
    .lock_o (lock),
    .hold_o (hold),
    .ptr_o  (ptr)
  );

  always_comb begin
    fresh     = (|fix_req) ? fix_pick : rr_pick;
    hold_live = lock && (|(req_i & hold));
    grant_o   = hold_live ? hold : fresh;
  end

  // R3: one-hot and within the request vector
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  a_r3_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~req_i) == '0);
  // R2: idle means no grant
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |-> (grant_o == '0));
  // R4: a fresh decision with a fixed requester goes to the fixed class
  a_r4_fixed_first: assert property (@(posedge clk) disable iff (!rst_n)
    ((|fix_req) && !lock) |-> (|(grant_o & FIXED_MASK)));
  // R8: grant held while owner still requests and has not completed
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grant_o) && !done_i) |=>
      (((req_i & $past(grant_o)) == '0) || (grant_o == $past(grant_o))));
endmodule

// File: tb/sim_hybrid_req_arbiter.sv
`timescale 1ns/100ps
module sim_hybrid_req_arbiter;
  localparam int unsigned N = 5;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] req;
  logic         done;
  logic [N-1:0] grant;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } item_t;
  item_t sb[$];

  hybrid_req_arbiter #(.N_REQ(N), .FIXED_MASK(5'b00011)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done), .grant_o(grant)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s grant=%b expected=%b", tag, act, exp);
    end
  endtask

  // Monitor: pops expected grants shortly after each falling edge.
  always @(negedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(grant, it.exp, it.tag);
      chk(grant & ~req, '0, "R3");
    end
  end

  task automatic step(input logic [N-1:0] r, input logic d,
                      input logic [N-1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    req  = r;
    done = d;
    it.exp = e;
    it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog grant=%b expected=done", grant);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req   = '0;
    done  = 1'b0;
    #7;
    chk(grant, 5'b00000, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    step(5'b00000, 1'b0, 5'b00000, "R2");
    step(5'b11100, 1'b1, 5'b00100, "R1");  // pointer at 0
    step(5'b11100, 1'b1, 5'b01000, "R6");
    step(5'b11100, 1'b1, 5'b10000, "R6");
    step(5'b11100, 1'b1, 5'b00100, "R6");  // wrap
    step(5'b11110, 1'b1, 5'b00010, "R4");
    step(5'b11111, 1'b1, 5'b00001, "R5");
    step(5'b10100, 1'b0, 5'b10000, "R7");  // fixed grants left pointer at 3
    step(5'b10111, 1'b0, 5'b10000, "R8");
    step(5'b10011, 1'b1, 5'b10000, "R8");  // release and completion together
    step(5'b01100, 1'b0, 5'b00100, "R6");  // pointer wrapped to 0
    step(5'b01000, 1'b0, 5'b01000, "R9");
    step(5'b00000, 1'b1, 5'b00000, "R10");
    step(5'b01100, 1'b1, 5'b00100, "R10"); // pointer still 0
    step(5'b00000, 1'b0, 5'b00000, "R2");
    step(5'b00110, 1'b0, 5'b00010, "R4");
    step(5'b00111, 1'b0, 5'b00010, "R8");
    step(5'b00101, 1'b1, 5'b00001, "R9");  // owner drops as completion arrives
    step(5'b00100, 1'b1, 5'b00100, "R6");
    step(5'b00000, 1'b0, 5'b00000, "R2");
    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule